// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Comparator with Lock Detection

This block compares a reference event stream with a feedback event stream on each of two channels and turns the phase difference into up and down enables for an external charge pump. When both enables are low, the pump output is meant to float (high impedance). A per-channel polarity input selects which enable a leading reference produces, so that loop filters and oscillators of either sense can be used. The whole block runs on the oscillator clock. Each event input is a one-cycle strobe taken on that clock.

Each channel counts, in clock ticks, how far apart its two events are and passes that count to its own lock tracker. The channel locks after a run of comparisons with a small error. It unlocks as soon as a running error reaches the unlock distance. A single lock output combines both channels. A channel held in power save counts as locked in that combination. While in power save its pump enables are held off. When it leaves power save, it starts over from unlocked.

Top module: `dual_pfd_lock`

## Requirements
- R1: On synchronous reset every up, down and lock output reads 0 after the next clock edge.
- R2: With polarity bit 1, a reference event alone on an idle channel raises up (down stays 0) from the next cycle. Up stays high until the edge after the closing feedback event, and then both enables are 0.
- R3: With polarity bit 0, the roles swap. A leading reference raises down, and a leading feedback raises up (with bit 1 a leading feedback raises down).
- R4: Reference and feedback events in the same cycle give exactly one cycle with up and down both 1, then both 0. No other stimulus drives both enables high together.
- R5: A second event on the side that already leads leaves the enable unchanged. The lead is held, not reversed, so the detection range covers a full cycle slip each way.
- R6: The error is the number of clock cycles from the leading event to the closing event. It saturates at 2^ERR_W-1 and never wraps.
- R7: An unlocked channel locks once LOCK_CYCLES consecutive comparisons (default 3) each have an error of at most LOCK_TICKS (default 4). A larger error restarts the run.
- R8: A locked channel unlocks in the cycle in which its running or measured error reaches UNLOCK_TICKS (default 2).
- R9: A channel in power save holds up and down at 0 and counts as locked in the combined flag.
- R10: A channel leaving power save is unlocked, and its run of good comparisons is empty.
- R11: The lock output is the AND over channels of (channel locked or channel in power save). It is registered one cycle after the channel state it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | N_CH | Power-save request per channel |
| fc_i | input | N_CH | Output polarity per channel |
| ref_i | input | N_CH | Reference event strobe per channel |
| fb_i | input | N_CH | Feedback event strobe per channel |
| up_o | output | N_CH | Pump source enable per channel |
| dn_o | output | N_CH | Pump sink enable per channel |
| lock_o | output | 1 | Combined lock flag |

## Verification
The bench builds the block with two channels and ERR_W of 4, so the error counter saturates at 15. A 17-cycle separation then reaches the point where a wrapping counter would read 1 and falsely count as a good comparison. The lock, unlock and run-length thresholds keep their defaults (4, 2 and 3), so lock and loss of lock both appear within a few dozen cycles. Holding the second channel in power save lets the combined flag expose the first channel's lock state alone, and waking it shows the restart from unlocked.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REF  = 2'd1,
    PH_FB   = 2'd2
  } phase_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
#(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             fc_i,
  input  logic             ref_i,
  input  logic             fb_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             done_o,
  output logic [ERR_W-1:0] meas_o,
  output logic             lead_d_o,
  output logic [ERR_W-1:0] run_cnt_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  phase_e           ph_q, ph_d;
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             pair_ev;

  assign pair_ev = ref_i & fb_i;

  always_comb begin
    ph_d   = ph_q;
    done_o = 1'b0;
    meas_o = '0;
    if (sleep_i) begin
      ph_d = PH_IDLE;
    end else if (pair_ev) begin
      ph_d   = PH_IDLE;
      done_o = 1'b1;
      meas_o = (ph_q == PH_IDLE) ? '0 : cnt_q;
    end else if (ref_i) begin
      if (ph_q == PH_FB) begin
        ph_d   = PH_IDLE;
        done_o = 1'b1;
        meas_o = cnt_q;
      end else begin
        ph_d = PH_REF;
      end
    end else if (fb_i) begin
      if (ph_q == PH_REF) begin
        ph_d   = PH_IDLE;
        done_o = 1'b1;
        meas_o = cnt_q;
      end else begin
        ph_d = PH_FB;
      end
    end
  end

  always_comb begin
    if (ph_d == PH_IDLE)      cnt_d = '0;
    else if (ph_q == PH_IDLE) cnt_d = {{(ERR_W-1){1'b0}}, 1'b1};
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  assign lead_d_o  = (ph_d != PH_IDLE);
  assign run_cnt_o = cnt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      up_o  <= (pair_ev & ~sleep_i) | ((ph_d == PH_REF) & fc_i) | ((ph_d == PH_FB) & ~fc_i);
      dn_o  <= (pair_ev & ~sleep_i) | ((ph_d == PH_REF) & ~fc_i) | ((ph_d == PH_FB) & fc_i);
    end
  end
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int ERR_W        = 6,
  parameter int UNLOCK_TICKS = 2,
  parameter int LOCK_TICKS   = 4,
  parameter int LOCK_CYCLES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             done_i,
  input  logic [ERR_W-1:0] meas_i,
  input  logic             lead_i,
  input  logic [ERR_W-1:0] run_cnt_i,
  output logic             locked_o
);
  localparam int GW = $clog2(LOCK_CYCLES + 1);
  localparam logic [ERR_W-1:0] UNL  = ERR_W'(UNLOCK_TICKS);
  localparam logic [ERR_W-1:0] LKT  = ERR_W'(LOCK_TICKS);
  localparam logic [GW-1:0]    GOAL = GW'(LOCK_CYCLES);

  logic [GW-1:0] good_q;
  logic [GW-1:0] good_inc;
  logic          lose;

  assign good_inc = good_q + 1'b1;
  assign lose     = (lead_i && run_cnt_i >= UNL) || (done_i && meas_i >= UNL);

  always_ff @(posedge clk) begin
    if (rst || sleep_i) begin
      locked_o <= 1'b0;
      good_q   <= '0;
    end else if (locked_o) begin
      if (lose) begin
        locked_o <= 1'b0;
        good_q   <= '0;
      end
    end else if (done_i) begin
      if (meas_i <= LKT) begin
        if (good_inc >= GOAL) begin
          locked_o <= 1'b1;
          good_q   <= '0;
        end else begin
          good_q <= good_inc;
        end
      end else begin
        good_q <= '0;
      end
    end
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int N_CH         = 2,
  parameter int ERR_W        = 6,
  parameter int UNLOCK_TICKS = 2,
  parameter int LOCK_TICKS   = 4,
  parameter int LOCK_CYCLES  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] sleep_i,
  input  logic [N_CH-1:0] fc_i,
  input  logic [N_CH-1:0] ref_i,
  input  logic [N_CH-1:0] fb_i,
  output logic [N_CH-1:0] up_o,
  output logic [N_CH-1:0] dn_o,
  output logic            lock_o
);
  logic [N_CH-1:0] ch_lock;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             done;
    logic             lead;
    logic [ERR_W-1:0] meas;
    logic [ERR_W-1:0] run_cnt;

    pfd_core #(.ERR_W(ERR_W)) u_core (
      .clk(clk), .rst(rst), .sleep_i(sleep_i[c]), .fc_i(fc_i[c]),
      .ref_i(ref_i[c]), .fb_i(fb_i[c]), .up_o(up_o[c]), .dn_o(dn_o[c]),
      .done_o(done), .meas_o(meas), .lead_d_o(lead), .run_cnt_o(run_cnt)
    );

    lock_tracker #(
      .ERR_W(ERR_W), .UNLOCK_TICKS(UNLOCK_TICKS),
      .LOCK_TICKS(LOCK_TICKS), .LOCK_CYCLES(LOCK_CYCLES)
    ) u_lock (
      .clk(clk), .rst(rst), .sleep_i(sleep_i[c]), .done_i(done),
      .meas_i(meas), .lead_i(lead), .run_cnt_i(run_cnt), .locked_o(ch_lock[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lock_o <= 1'b0;
    else     lock_o <= &(ch_lock | sleep_i);
  end
endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] sleep_i,
  input logic [N_CH-1:0] fc_i,
  input logic [N_CH-1:0] ref_i,
  input logic [N_CH-1:0] fb_i,
  input logic [N_CH-1:0] up_o,
  input logic [N_CH-1:0] dn_o,
  input logic            lock_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (lock_o == 1'b0 && up_o == '0 && dn_o == '0));

  assert_all_asleep_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (&sleep_i) |=> lock_o);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_sleep_floats_R9: assert property (@(posedge clk) disable iff (rst)
      sleep_i[c] |=> (!up_o[c] && !dn_o[c]));

    assert_pair_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      (ref_i[c] && fb_i[c] && !sleep_i[c]) |=> (up_o[c] && dn_o[c]));

    assert_pulse_only_from_pair_R4: assert property (@(posedge clk) disable iff (rst)
      !(ref_i[c] && fb_i[c]) |=> !(up_o[c] && dn_o[c]));

    assert_ref_lead_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (up_o[c] && !dn_o[c] && fc_i[c] && !fb_i[c] && !sleep_i[c]) |=> (up_o[c] && !dn_o[c]));
  end
endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .fc_i(fc_i), .ref_i(ref_i),
  .fb_i(fb_i), .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
);

// File: tb/sim_dual_pfd_lock.sv
module sim_dual_pfd_lock;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 2;
  localparam int EW  = 4;
  localparam int CMAX = (1 << EW) - 1;
  localparam int UNL = 2;
  localparam int LKT = 4;
  localparam int LKC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] sleep_i = '0, fc_i = '0, ref_i = '0, fb_i = '0;
  logic [N-1:0] up_o, dn_o;
  logic lock_o;

  int vectors = 0;
  int fails = 0;

  int st[N], cnt[N], mup[N], mdn[N], locked[N], good[N];
  int mlock;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_pfd_lock #(.N_CH(N), .ERR_W(EW), .UNLOCK_TICKS(UNL),
                  .LOCK_TICKS(LKT), .LOCK_CYCLES(LKC)) u0 (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .fc_i(fc_i), .ref_i(ref_i),
    .fb_i(fb_i), .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
  );

  task automatic model_step();
    int all;
    if (rst) begin
      mlock = 0;
      for (int i = 0; i < N; i++) begin
        st[i] = 0; cnt[i] = 0; mup[i] = 0; mdn[i] = 0; locked[i] = 0; good[i] = 0;
      end
      return;
    end
    all = 1;
    for (int i = 0; i < N; i++) if (!(locked[i] != 0 || sleep_i[i])) all = 0;
    mlock = all;
    for (int i = 0; i < N; i++) begin
      int nst, ncnt, meas, done;
      if (sleep_i[i]) begin
        st[i] = 0; cnt[i] = 0; mup[i] = 0; mdn[i] = 0; locked[i] = 0; good[i] = 0;
        continue;
      end
      done = 0; meas = 0; nst = st[i];
      if (ref_i[i] && fb_i[i]) begin
        done = 1; meas = (st[i] == 0) ? 0 : cnt[i]; nst = 0;
      end else if (ref_i[i]) begin
        if (st[i] == 2) begin done = 1; meas = cnt[i]; nst = 0; end else nst = 1;
      end else if (fb_i[i]) begin
        if (st[i] == 1) begin done = 1; meas = cnt[i]; nst = 0; end else nst = 2;
      end
      if (nst == 0) ncnt = 0;
      else if (st[i] == 0) ncnt = 1;
      else ncnt = (cnt[i] + 1 > CMAX) ? CMAX : cnt[i] + 1;
      mup[i] = ((ref_i[i] && fb_i[i]) || (nst == 1 && fc_i[i]) || (nst == 2 && !fc_i[i])) ? 1 : 0;
      mdn[i] = ((ref_i[i] && fb_i[i]) || (nst == 1 && !fc_i[i]) || (nst == 2 && fc_i[i])) ? 1 : 0;
      if (locked[i] != 0) begin
        if ((nst != 0 && ncnt >= UNL) || (done != 0 && meas >= UNL)) begin
          locked[i] = 0; good[i] = 0;
        end
      end else if (done != 0) begin
        if (meas <= LKT) begin
          if (good[i] + 1 >= LKC) begin locked[i] = 1; good[i] = 0; end
          else good[i] = good[i] + 1;
        end else good[i] = 0;
      end
      st[i] = nst; cnt[i] = ncnt;
    end
  endtask

  task automatic compare(input string tag);
    logic [N-1:0] eu, ed;
    for (int i = 0; i < N; i++) begin eu[i] = mup[i][0]; ed[i] = mdn[i][0]; end
    vectors++;
    if (up_o !== eu || dn_o !== ed || lock_o !== mlock[0]) begin
      fails++;
      $display("FAIL %s up=%b dn=%b lock=%b expected up=%b dn=%b lock=%b",
               tag, up_o, dn_o, lock_o, eu, ed, mlock[0]);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] f, input string tag);
    ref_i = r; fb_i = f;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ref_i = '0; fb_i = '0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc('0, '0, tag);
  endtask

  // first strobes, then k-1 idle cycles, then closing strobes: error k
  task automatic pair(input logic [N-1:0] r1, input logic [N-1:0] f1,
                      input logic [N-1:0] r2, input logic [N-1:0] f2,
                      input int k, input string tag);
    cyc(r1, f1, tag);
    idle(k - 1, tag);
    cyc(r2, f2, tag);
    idle(2, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired before completion (expected end of stimulus)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    idle(3, "R1");
    rst = 1'b0;
    idle(2, "R1");

    // channel 1 asleep so lock_o shows channel 0 (R9)
    sleep_i = 2'b10; fc_i = 2'b11;
    idle(2, "R9");
    for (int j = 0; j < 3; j++) pair(2'b01, '0, '0, 2'b01, 3, "R2");
    idle(3, "R7");
    // locked: a running error of 2 drops lock
    pair(2'b01, '0, '0, 2'b01, 6, "R8");

    // polarity 0 on channel 0
    fc_i = 2'b10;
    pair(2'b01, '0, '0, 2'b01, 3, "R3");
    pair('0, 2'b01, 2'b01, '0, 3, "R3");
    fc_i = 2'b11;
    pair('0, 2'b01, 2'b01, '0, 2, "R3");

    // simultaneous strobes
    cyc(2'b01, 2'b01, "R4");
    idle(3, "R4");
    cyc(2'b01, 2'b01, "R4");
    cyc(2'b01, 2'b01, "R4");
    idle(3, "R4");

    // repeated leading event holds the lead
    cyc(2'b01, '0, "R5");
    idle(2, "R5");
    cyc(2'b01, '0, "R5");
    idle(2, "R5");
    cyc('0, 2'b01, "R5");
    idle(3, "R5");

    // saturation: 17-cycle errors must not count as good
    for (int j = 0; j < 3; j++) pair(2'b01, '0, '0, 2'b01, 17, "R6");
    idle(3, "R6");
    for (int j = 0; j < 2; j++) pair(2'b01, '0, '0, 2'b01, 2, "R7");
    pair(2'b01, '0, '0, 2'b01, 6, "R7");
    for (int j = 0; j < 3; j++) pair(2'b01, '0, '0, 2'b01, 4, "R7");
    idle(3, "R7");

    // both asleep, then channel 0 wakes unlocked
    sleep_i = 2'b11;
    idle(3, "R9");
    sleep_i = 2'b10;
    idle(3, "R10");
    for (int j = 0; j < 2; j++) pair(2'b01, '0, '0, 2'b01, 1, "R10");
    idle(2, "R10");
    pair(2'b01, '0, '0, 2'b01, 1, "R10");
    idle(2, "R10");

    // both channels awake
    sleep_i = 2'b00; fc_i = 2'b01;
    idle(2, "R11");
    for (int j = 0; j < 3; j++) pair(2'b01, 2'b10, 2'b10, 2'b01, 2, "R11");
    for (int j = 0; j < 3; j++) pair(2'b11, 2'b00, 2'b00, 2'b11, 1, "R11");
    idle(3, "R11");
    pair(2'b10, '0, '0, 2'b10, 5, "R11");
    idle(3, "R11");
    rst = 1'b1;
    idle(2, "R1");
    rst = 1'b0;
    idle(2, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule